// File: doc/BRIEF.md
# NRZI Line Encoder with Bit Stuffing

This block is the bit-level back end of a full-speed serial transmitter. A source hands it payload bits one at a time over a valid/ready handshake and marks the final bit of each packet. Every packet opens with a synchronisation pattern. Payload bits then go onto a differential pair using NRZI coding. A zero is inserted after each long run of ones so that the receiver always sees edges it can lock onto.

A bit-rate strobe sets the pace, and the block moves exactly one bit per strobe. The two line outputs are always complements of each other. A separate enable output is high while the block drives the pair. Between packets the line rests at the J level (positive line high). While a stuffed zero is on the line, the source is held off for that bit time.

Top module: `nrzi_tx_encoder`

## Requirements
- R1: After reset and between packets, `line_oe` is 0, `line_p` is 1, `line_n` is 0, and `src_ready` is 0. A strobe without `src_valid` leaves this state unchanged.
- R2: A strobe that sees `src_valid` while idle starts a packet. That strobe and the next seven put the sync pattern 0x80 on the line, least significant bit first (seven 0 bits, then one 1 bit), with `line_oe` high.
- R3: Each line bit is NRZI coded, starting from the idle J level. A 0 bit toggles `line_p`, and a 1 bit leaves it unchanged.
- R4: After six consecutive payload 1 bits, one extra 0 bit is sent. This also happens when the sixth 1 is the last bit of the packet. The run count restarts on every payload 0 and on every stuffed bit. Sync bits do not count toward a run.
- R5: `src_ready` is 0 during the strobes that send sync bits and during the strobe that sends a stuffed bit. It is 1 during every strobe that sends a payload bit. A payload bit is taken at a strobe where both `src_valid` and `src_ready` are 1.
- R6: The line outputs change only on a clock edge where `bit_stb` is 1. Between strobes they hold.
- R7: `line_n` is the logical complement of `line_p` on every cycle.
- R8: At the strobe after the last payload bit (or after the stuffed bit that follows it), `line_oe` falls and the line returns to J. A packet of L payload bits with S stuffed bits therefore keeps `line_oe` high for 8+L+S bit times.
- R9: A strobe during the payload phase that finds `src_valid` low ends the packet at once. At that strobe `line_oe` falls and the line returns to J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | Bit-rate strobe, one line bit per pulse |
| src_valid | input | 1 | Source offers a payload bit |
| src_bit | input | 1 | Payload bit value |
| src_last | input | 1 | Offered bit is the final bit of the packet |
| src_ready | output | 1 | Encoder takes the offered bit at the next strobe |
| line_p | output | 1 | Positive line of the differential pair |
| line_n | output | 1 | Negative line, always the complement of line_p |
| line_oe | output | 1 | High while the encoder drives the pair |

## Verification
The bench builds the block with its default parameters. These are an 8-bit sync pattern of 0x80 and a stuffing threshold of six ones. With a threshold this short, a single byte of ones already forces a stuffed bit. This makes several cases reachable within packets of at most sixteen bits: repeated stuffing, stuffing on the final bit, and a run broken by a zero one bit short of the threshold. The bench also confirms that the one-bit run closing the sync pattern does not shorten the first payload run. It decodes the observed line back to bits from the J level and compares the result with a stream built from the requirements.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;

  // Sequencer phases of one packet on the wire
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SYNC  = 3'd1,
    ST_DATA  = 3'd2,
    ST_STUFF = 3'd3,
    ST_TAIL  = 3'd4
  } tx_state_e;

endpackage

// File: rtl/nrzi_tx_runlen.sv
module nrzi_tx_runlen #(
  parameter int STUFF_RUN = 6,
  localparam int RUN_W = $clog2(STUFF_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             one_bit,
  input  logic             clear,
  output logic [RUN_W-1:0] run_cnt
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      run_cnt <= '0;
    end else if (step) begin
      if (one_bit) run_cnt <= run_cnt + RUN_W'(1);
      else         run_cnt <= '0;
    end
  end

  // R4: the sequencer must break any run before it exceeds the threshold
  a_r4_run_limit: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= RUN_W'(STUFF_RUN));

endmodule

// File: rtl/nrzi_tx_seq.sv
module nrzi_tx_seq
  import nrzi_tx_pkg::*;
#(
  parameter int                   SYNC_BITS    = 8,
  parameter logic [SYNC_BITS-1:0] SYNC_PATTERN = 8'h80,
  parameter int                   STUFF_RUN    = 6,
  localparam int RUN_W = $clog2(STUFF_RUN + 1),
  localparam int IDX_W = $clog2(SYNC_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             src_valid,
  input  logic             src_bit,
  input  logic             src_last,
  input  logic [RUN_W-1:0] run_cnt,
  output logic             src_ready,
  output logic             drive,
  output logic             line_bit,
  output logic             run_step,
  output logic             run_one,
  output logic             run_clear
);

  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(SYNC_BITS - 1);
  localparam logic [RUN_W-1:0] PRE_STUFF = RUN_W'(STUFF_RUN - 1);

  tx_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ready_q, ready_d;
  logic             end_q, end_d;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    ready_d   = ready_q;
    end_d     = end_q;
    drive     = 1'b0;
    line_bit  = 1'b1;
    run_step  = 1'b0;
    run_one   = 1'b0;
    run_clear = 1'b0;
    if (bit_stb) begin
      unique case (state_q)
        ST_IDLE: begin
          run_clear = 1'b1;
          if (src_valid) begin
            drive    = 1'b1;
            line_bit = SYNC_PATTERN[0];
            idx_d    = IDX_W'(1);
            state_d  = ST_SYNC;
          end
        end
        ST_SYNC: begin
          drive     = 1'b1;
          line_bit  = SYNC_PATTERN[idx_q];
          run_clear = 1'b1;
          if (idx_q == LAST_IDX) begin
            state_d = ST_DATA;
            ready_d = 1'b1;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
        ST_DATA: begin
          if (src_valid) begin
            drive    = 1'b1;
            line_bit = src_bit;
            run_step = 1'b1;
            run_one  = src_bit;
            if (src_bit && run_cnt == PRE_STUFF) begin
              state_d = ST_STUFF;
              ready_d = 1'b0;
              end_d   = src_last;
            end else if (src_last) begin
              state_d = ST_TAIL;
              ready_d = 1'b0;
            end
          end else begin
            state_d = ST_IDLE;
            ready_d = 1'b0;
          end
        end
        ST_STUFF: begin
          drive    = 1'b1;
          line_bit = 1'b0;
          run_step = 1'b1;
          run_one  = 1'b0;
          state_d  = end_q ? ST_TAIL : ST_DATA;
          ready_d  = ~end_q;
          end_d    = 1'b0;
        end
        ST_TAIL: begin
          state_d = ST_IDLE;
          ready_d = 1'b0;
        end
        default: begin
          state_d = ST_IDLE;
          ready_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ready_q <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ready_q <= ready_d;
      end_q   <= end_d;
    end
  end

  assign src_ready = ready_q;

  // R5: no payload bit is taken outside the payload phase
  a_r5_ready_only_data: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_DATA) |-> !src_ready);

  // R4: a full run of ones must be followed by the stuffed bit
  a_r4_full_run_stuffs: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == RUN_W'(STUFF_RUN)) |-> (state_q == ST_STUFF));

  // R9: a payload strobe without data returns to idle
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && state_q == ST_DATA && !src_valid) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/nrzi_tx_line.sv
module nrzi_tx_line (
  input  logic clk,
  input  logic rst,
  input  logic bit_stb,
  input  logic drive,
  input  logic line_bit,
  output logic line_p,
  output logic line_n,
  output logic line_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_p  <= 1'b1;
      line_n  <= 1'b0;
      line_oe <= 1'b0;
    end else if (bit_stb) begin
      if (drive) begin
        line_oe <= 1'b1;
        if (!line_bit) begin
          line_p <= ~line_p;
          line_n <= ~line_n;
        end
      end else begin
        line_oe <= 1'b0;
        line_p  <= 1'b1;
        line_n  <= 1'b0;
      end
    end
  end

  // R7: the two line flops never agree
  a_r7_complement: assert property (@(posedge clk) disable iff (rst)
    line_p != line_n);

  // R1: an undriven line rests at J
  a_r1_idle_j: assert property (@(posedge clk) disable iff (rst)
    !line_oe |-> (line_p && !line_n));

  // R3: a zero bit flips the level, a one bit keeps it
  a_r3_zero_toggles: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && drive && !line_bit) |=> (line_p != $past(line_p)));
  a_r3_one_holds: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && drive && line_bit) |=> $stable(line_p));

  // R6: nothing moves between strobes
  a_r6_hold_gap: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> ($stable(line_p) && $stable(line_oe)));

endmodule

// File: rtl/nrzi_tx_encoder.sv
module nrzi_tx_encoder #(
  parameter int                   SYNC_BITS    = 8,
  parameter logic [SYNC_BITS-1:0] SYNC_PATTERN = 8'h80,
  parameter int                   STUFF_RUN    = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_stb,
  input  logic src_valid,
  input  logic src_bit,
  input  logic src_last,
  output logic src_ready,
  output logic line_p,
  output logic line_n,
  output logic line_oe
);

  localparam int RUN_W = $clog2(STUFF_RUN + 1);

  logic [RUN_W-1:0] run_cnt;
  logic             drive, line_bit, run_step, run_one, run_clear;

  nrzi_tx_seq #(
    .SYNC_BITS   (SYNC_BITS),
    .SYNC_PATTERN(SYNC_PATTERN),
    .STUFF_RUN   (STUFF_RUN)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .bit_stb  (bit_stb),
    .src_valid(src_valid),
    .src_bit  (src_bit),
    .src_last (src_last),
    .run_cnt  (run_cnt),
    .src_ready(src_ready),
    .drive    (drive),
    .line_bit (line_bit),
    .run_step (run_step),
    .run_one  (run_one),
    .run_clear(run_clear)
  );

  nrzi_tx_runlen #(
    .STUFF_RUN(STUFF_RUN)
  ) u_runlen (
    .clk    (clk),
    .rst    (rst),
    .step   (run_step),
    .one_bit(run_one),
    .clear  (run_clear),
    .run_cnt(run_cnt)
  );

  nrzi_tx_line u_line (
    .clk     (clk),
    .rst     (rst),
    .bit_stb (bit_stb),
    .drive   (drive),
    .line_bit(line_bit),
    .line_p  (line_p),
    .line_n  (line_n),
    .line_oe (line_oe)
  );

endmodule

// File: tb/nrzi_tx_encoder_bench.sv
module nrzi_tx_encoder_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_stb = 1'b0;
  logic src_valid = 1'b0;
  logic src_bit = 1'b0;
  logic src_last = 1'b0;
  logic src_ready, line_p, line_n, line_oe;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  nrzi_tx_encoder u_nrzi_tx_encoder (
    .clk      (clk),
    .rst      (rst),
    .bit_stb  (bit_stb),
    .src_valid(src_valid),
    .src_bit  (src_bit),
    .src_last (src_last),
    .src_ready(src_ready),
    .line_p   (line_p),
    .line_n   (line_n),
    .line_oe  (line_oe)
  );

  // {payload length, expected stuffed bits, payload LSB first}
  localparam logic [22:0] VECS [0:7] = '{
    {5'd8,  2'd0, 16'h0000},  // zeros only
    {5'd8,  2'd1, 16'h00FF},  // run of eight ones
    {5'd16, 2'd2, 16'hFFFF},  // two stuffs in one packet
    {5'd6,  2'd1, 16'h003F},  // sixth one is the last bit
    {5'd12, 2'd0, 16'h07DF},  // runs of five broken by zeros
    {5'd1,  2'd0, 16'h0001},  // single bit
    {5'd7,  2'd1, 16'h007E},  // zero then six ones
    {5'd14, 2'd2, 16'h3F7F}   // seven ones, zero, six ones at the end
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One strobe: called at a negedge, returns at a negedge with outputs settled.
  task automatic strobe(output logic rdy);
    logic p0, oe0;
    rdy = src_ready;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    p0 = line_p;
    oe0 = line_oe;
    repeat (2) @(negedge clk);
    chk(line_p == p0 && line_oe == oe0, "R6", "hold between strobes",
        int'({line_p, line_oe}), int'({p0, oe0}));
    @(negedge clk);
  endtask

  task automatic run_packet(input logic [22:0] v);
    int len, stf, n_exp, run, idx, nobs;
    int exp_bit [64];
    int is_pay [64];
    logic [15:0] data;
    logic prev, rdy, started, done;
    len  = int'(v[22:18]);
    stf  = int'(v[17:16]);
    data = v[15:0];
    // expected bit stream: sync 0x80 LSB first, then stuffed payload
    n_exp = 0;
    for (int i = 0; i < 8; i++) begin
      exp_bit[n_exp] = (i == 7) ? 1 : 0;
      is_pay[n_exp] = 0;
      n_exp++;
    end
    run = 0;
    for (int i = 0; i < len; i++) begin
      exp_bit[n_exp] = int'(data[i]);
      is_pay[n_exp] = 1;
      n_exp++;
      run = data[i] ? run + 1 : 0;
      if (run == 6) begin
        exp_bit[n_exp] = 0;
        is_pay[n_exp] = 0;
        n_exp++;
        run = 0;
      end
    end
    chk(n_exp == 8 + len + stf, "R4", "model stuff count", n_exp, 8 + len + stf);
    idx = 0;
    src_valid = 1'b1;
    src_bit = data[0];
    src_last = (len == 1);
    nobs = 0;
    prev = 1'b1;
    started = 1'b0;
    done = 1'b0;
    for (int s = 0; s < 100 && !done; s++) begin
      strobe(rdy);
      chk(line_n == ~line_p, "R7", "complement", int'(line_n), int'(~line_p));
      if (line_oe) begin
        if (nobs < 64) begin
          chk(int'(line_p == prev) == exp_bit[nobs],
              (nobs < 8) ? "R2" : (is_pay[nobs] != 0) ? "R3" : "R4",
              "decoded bit", int'(line_p == prev), exp_bit[nobs]);
          chk(int'(rdy) == is_pay[nobs], "R5", "ready at strobe",
              int'(rdy), is_pay[nobs]);
          prev = line_p;
        end
        nobs++;
        started = 1'b1;
      end else if (started) begin
        done = 1'b1;
      end else begin
        chk(1'b0, "R2", "packet start", 0, 1);
        done = 1'b1;
      end
      if (rdy && src_valid) begin
        idx++;
        if (idx < len) begin
          src_bit = data[idx];
          src_last = (idx == len - 1);
        end else begin
          src_valid = 1'b0;
          src_last = 1'b0;
        end
      end
    end
    chk(nobs == 8 + len + stf, "R8", "driven bit times", nobs, 8 + len + stf);
    chk(idx == len, "R5", "payload bits taken", idx, len);
    chk(line_p == 1'b1 && line_n == 1'b0, "R8", "J after packet",
        int'(line_p), 1);
    chk(src_ready == 1'b0, "R1", "ready low after packet", int'(src_ready), 0);
  endtask

  initial begin
    #2_000_000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic rdy;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(line_oe == 1'b0, "R1", "oe after reset", int'(line_oe), 0);
    chk(line_p == 1'b1 && line_n == 1'b0, "R1", "J after reset",
        int'({line_p, line_n}), 2);
    chk(src_ready == 1'b0, "R1", "ready after reset", int'(src_ready), 0);
    // R1: strobes without valid leave the line idle
    for (int k = 0; k < 3; k++) begin
      strobe(rdy);
      chk(line_oe == 1'b0 && line_p == 1'b1, "R1", "idle strobe",
          int'({line_oe, line_p}), 1);
    end
    // table of packets
    for (int i = 0; i < 8; i++) run_packet(VECS[i]);
    // R9: abort mid payload
    src_valid = 1'b1;
    src_bit = 1'b0;
    src_last = 1'b0;
    for (int k = 0; k < 11; k++) strobe(rdy);
    chk(line_oe == 1'b1, "R9", "driving before abort", int'(line_oe), 1);
    src_valid = 1'b0;
    strobe(rdy);
    chk(line_oe == 1'b0, "R9", "oe after abort", int'(line_oe), 0);
    chk(line_p == 1'b1 && line_n == 1'b0, "R9", "J after abort",
        int'({line_p, line_n}), 2);
    chk(src_ready == 1'b0, "R9", "ready after abort", int'(src_ready), 0);
    strobe(rdy);
    chk(line_oe == 1'b0, "R1", "stays idle after abort", int'(line_oe), 0);
    // R2: a fresh packet after the abort still starts with sync
    run_packet(VECS[1]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule